// File: doc/BRIEF.md
# Graphics Command Packet Framer

This block sits behind the data port of a graphics command interface. It takes a stream of 32-bit words and cuts it into whole command packets. The top byte of the first word of each packet is the opcode. A per-opcode table gives the number of parameter words that follow. When every word of a packet has arrived, the block plays the packet out one word per cycle, together with its opcode, total length and the index of each word. Words that do not yet complete a packet stay in the block until the rest arrive, however long the input pauses.

Two opcode families are treated specially. The environment family (0xE0 to 0xE7) also writes its word into one of eight shadow registers. The low 13 bits of a 32-bit status word follow two of those registers. The memory-transfer opcodes (0xA0 for writes into image memory, 0xC0 for reads from it) are not played out as packets. They hand a decoded rectangle to a separate pixel-transfer unit. For a write, the block then passes the following pixel words to that unit before framing resumes.

Top module: `gpf_cmd_framer`

## Requirements
- R1: The opcode is bits 31:24 of a packet's first word. The packet length is 1 plus the table entry for that opcode. Every opcode not listed in R2, R3 or R9 has an entry of 0 and forms a one-word packet.
- R2: Table entries for 0x20 to 0x3F, in groups of four opcodes starting at 0x20: 3, 6, 4, 8, 5, 8, 7, 11.
- R3: Table entries: 0x02 → 2, 0x40–0x47 → 2, 0x48–0x57 → 3, 0x58–0x5F → 4, 0x60–0x63 → 2, 0x64–0x67 → 3, 0x68–0x6B → 1, 0x6C–0x6F → 0, 0x70–0x73 → 1, 0x74–0x77 → 2, 0x78–0x7B → 1, 0x7C–0x7F → 2, 0x80 → 3.
- R4: Suppose the last word of a packet is accepted at clock edge t. Then `pkt_valid` is high from the cycle after t for exactly `pkt_len` consecutive cycles. During those cycles `pkt_idx` counts 0 to `pkt_len`-1 and `pkt_word` carries the words in arrival order. `pkt_last` marks the final word, and `pkt_op` and `pkt_len` stay steady.
- R5: `cmd_ready` is low exactly while `pkt_valid` is high. A word is accepted at a rising edge where both `cmd_valid` and `cmd_ready` are high. The words of an unfinished packet are held across any number of idle cycles.
- R6: When the first word of a packet has an opcode 0xE0–0xE7, the whole word is written to shadow register (opcode & 7) at the edge that accepts it. Shadow register i is output on `env_regs[32*i+31:32*i]`. The word still forms a one-word packet.
- R7: One cycle after any shadow change, `status_word[10:0]` equals bits 10:0 of shadow register 1 and `status_word[12:11]` equals bits 1:0 of shadow register 6. Bits 31:13 never change.
- R8: While reset is asserted, shadow register i holds (0xE0+i)<<24 and `status_word` is 0x14802000. `cmd_ready` is 1, and `pkt_valid`, `xfer_start` and `pix_valid` are 0.
- R9: Opcodes 0xA0 and 0xC0 take two parameter words: a position word, then a size word. They produce no packet. Instead, the cycle after the size word is accepted, `xfer_start` pulses for one cycle, with the fields below.
  - `xfer_is_read` = 1 for 0xC0.
  - `xfer_x` = position[9:0] and `xfer_y` = position[24:16].
  - `xfer_w` = size[9:0], or 1024 when that field is 0.
  - `xfer_h` = size[24:16], or 512 when that field is 0.
- R10: After a 0xA0 command, the next ceil(`xfer_w`*`xfer_h`/2) accepted words are not framed. Each one appears on `pix_data` with `pix_valid` high in the cycle after it is accepted, and framing then resumes. A 0xC0 command diverts no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Input word present |
| cmd_data | input | 32 | Input command or pixel word |
| cmd_ready | output | 1 | Block can take a word this cycle |
| pkt_valid | output | 1 | Packet word on output |
| pkt_op | output | 8 | Opcode of the packet being played out |
| pkt_len | output | 4 | Total words in the packet |
| pkt_idx | output | 4 | Index of the current word |
| pkt_last | output | 1 | Current word is the packet's last |
| pkt_word | output | 32 | Current packet word |
| xfer_start | output | 1 | One-cycle pulse: memory transfer decoded |
| xfer_is_read | output | 1 | Transfer reads image memory |
| xfer_x | output | 10 | Transfer origin column |
| xfer_y | output | 9 | Transfer origin row |
| xfer_w | output | 11 | Transfer width, 1 to 1024 |
| xfer_h | output | 10 | Transfer height, 1 to 512 |
| pix_valid | output | 1 | Diverted pixel word valid |
| pix_data | output | 32 | Diverted pixel word |
| env_regs | output | 256 | Eight shadow registers, register i in bits 32*i+31:32*i |
| status_word | output | 32 | Status word |

## Verification
The properties assume reset is applied before the first check. They also assume `cmd_valid` and `cmd_data` are never unknown at a rising edge. They place no rule on how long the source holds a word or how often it pauses, because acceptance is decided only by `cmd_ready`. The stimulus changes inputs on falling edges only. It holds each word until it sees `cmd_ready` high before the edge. It puts idle gaps inside packets, so the block is tested both while it is stalled mid-packet and while it is playing a packet out.

// File: rtl/gpf_pkg.sv
package gpf_pkg;

  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OP_MEM_WRITE = 8'hA0;
  localparam logic [OP_W-1:0] OP_MEM_READ  = 8'hC0;
  localparam logic [4:0]      OP_ENV_TOP   = 5'b11100;

  typedef enum logic [1:0] {
    ST_GATHER = 2'd0,
    ST_EMIT   = 2'd1,
    ST_PIXEL  = 2'd2
  } fr_state_t;

endpackage

// File: rtl/gpf_len_decode.sv
module gpf_len_decode #(
  parameter int LEN_W = 4
) (
  input  logic [7:0]       op,
  output logic [LEN_W-1:0] len
);

  logic [LEN_W-1:0] extra;

  always_comb begin
    extra = '0;
    case (op[7:5])
      3'd0: extra = (op == 8'h02) ? LEN_W'(2) : LEN_W'(0);
      3'd1: begin
        // bit4 = gouraud, bit3 = four corners, bit2 = textured
        case (op[4:2])
          3'd0:    extra = LEN_W'(3);
          3'd1:    extra = LEN_W'(6);
          3'd2:    extra = LEN_W'(4);
          3'd3:    extra = LEN_W'(8);
          3'd4:    extra = LEN_W'(5);
          3'd5:    extra = LEN_W'(8);
          3'd6:    extra = LEN_W'(7);
          default: extra = LEN_W'(11);
        endcase
      end
      3'd2: begin
        case (op[4:3])
          2'd0:    extra = LEN_W'(2);
          2'd3:    extra = LEN_W'(4);
          default: extra = LEN_W'(3);
        endcase
      end
      3'd3: begin
        case (op[4:2])
          3'd0:    extra = LEN_W'(2);
          3'd1:    extra = LEN_W'(3);
          3'd2:    extra = LEN_W'(1);
          3'd3:    extra = LEN_W'(0);
          3'd4:    extra = LEN_W'(1);
          3'd5:    extra = LEN_W'(2);
          3'd6:    extra = LEN_W'(1);
          default: extra = LEN_W'(2);
        endcase
      end
      3'd4:    extra = (op == 8'h80) ? LEN_W'(3) : LEN_W'(0);
      3'd5:    extra = (op == 8'hA0) ? LEN_W'(2) : LEN_W'(0);
      3'd6:    extra = (op == 8'hC0) ? LEN_W'(2) : LEN_W'(0);
      default: extra = '0;
    endcase
    len = extra + LEN_W'(1);
  end

endmodule

// File: rtl/gpf_env_file.sv
module gpf_env_file #(
  parameter int          DATA_W     = 32,
  parameter int          N_ENV      = 8,
  parameter logic [31:0] STATUS_RST = 32'h1480_2000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      env_we,
  input  logic [$clog2(N_ENV)-1:0]  env_sel,
  input  logic [DATA_W-1:0]         env_wdata,
  output logic [N_ENV*DATA_W-1:0]   env_flat,
  output logic [31:0]               status_word
);

  localparam int SEL_W  = $clog2(N_ENV);
  localparam int STLO_W = 13;

  logic [DATA_W-1:0] env_q [N_ENV];

  for (genvar k = 0; k < N_ENV; k++) begin : g_env
    localparam logic [7:0] TAG = 8'(8'hE0 + k);
    logic wr_en;
    assign wr_en = env_we && (env_sel == SEL_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        env_q[k] <= {TAG, {(DATA_W-8){1'b0}}};
      end else if (wr_en) begin
        env_q[k] <= env_wdata;
      end
    end
    assign env_flat[k*DATA_W +: DATA_W] = env_q[k];
  end

  logic [STLO_W-1:0] stlo_q, stlo_d;
  logic              stlo_en;

  always_comb begin
    stlo_d  = {env_q[6][1:0], env_q[1][10:0]};
    stlo_en = (stlo_d != stlo_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stlo_q <= STATUS_RST[STLO_W-1:0];
    end else if (stlo_en) begin
      stlo_q <= stlo_d;
    end
  end

  assign status_word = {STATUS_RST[31:STLO_W], stlo_q};

endmodule

// File: rtl/gpf_framer_core.sv
module gpf_framer_core
  import gpf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MAX_LEN = 12,
  parameter int XW      = 10,
  parameter int YW      = 9,
  parameter int N_ENV   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [DATA_W-1:0]         cmd_data,
  output logic                      cmd_ready,
  input  logic [$clog2(MAX_LEN+1)-1:0] dec_len,
  output logic                      env_we,
  output logic [$clog2(N_ENV)-1:0]  env_sel,
  output logic [DATA_W-1:0]         env_wdata,
  output logic                      pkt_valid,
  output logic [7:0]                pkt_op,
  output logic [$clog2(MAX_LEN+1)-1:0] pkt_len,
  output logic [$clog2(MAX_LEN+1)-1:0] pkt_idx,
  output logic                      pkt_last,
  output logic [DATA_W-1:0]         pkt_word,
  output logic                      xfer_start,
  output logic                      xfer_is_read,
  output logic [XW-1:0]             xfer_x,
  output logic [YW-1:0]             xfer_y,
  output logic [XW:0]               xfer_w,
  output logic [YW:0]               xfer_h,
  output logic                      pix_valid,
  output logic [DATA_W-1:0]         pix_data
);

  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int SEL_W = $clog2(N_ENV);
  localparam int WD_W  = XW + 1;
  localparam int HT_W  = YW + 1;
  localparam int PIX_W = WD_W + HT_W;

  fr_state_t          st_q, st_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d, need_q, need_d, idx_q, idx_d;
  logic [7:0]         op_q, op_d;
  logic [PIX_W-1:0]   left_q, left_d;

  logic               accept, gather_acc, first, done, is_xfer;
  logic [7:0]         cur_op;
  logic [LEN_W-1:0]   cur_need;
  logic [WD_W-1:0]    size_w;
  logic [HT_W-1:0]    size_h;
  logic [PIX_W-1:0]   area, words;
  logic               xs_load, pix_load;
  logic               xs_vld_q, pix_vld_q;

  // slot storage for one packet
  logic [DATA_W-1:0]  slot_rd [MAX_LEN];

  for (genvar k = 0; k < MAX_LEN; k++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              slot_en;
    assign slot_en = gather_acc && (cnt_q == LEN_W'(k));
    always_ff @(posedge clk) begin
      if (slot_en) begin
        slot_q <= cmd_data;
      end
    end
    assign slot_rd[k] = slot_q;
  end

  always_comb begin
    accept     = cmd_valid && (st_q != ST_EMIT);
    gather_acc = accept && (st_q == ST_GATHER);
    first      = (cnt_q == '0);
    cur_op     = first ? cmd_data[DATA_W-1 -: 8] : op_q;
    cur_need   = first ? dec_len : need_q;
    done       = gather_acc && (LEN_W'(cnt_q + 1'b1) == cur_need);
    is_xfer    = (cur_op == OP_MEM_WRITE) || (cur_op == OP_MEM_READ);
    size_w     = (cmd_data[XW-1:0] == '0) ? {1'b1, {XW{1'b0}}}
                                          : {1'b0, cmd_data[XW-1:0]};
    size_h     = (cmd_data[16 +: YW] == '0) ? {1'b1, {YW{1'b0}}}
                                            : {1'b0, cmd_data[16 +: YW]};
    area       = PIX_W'(size_w) * PIX_W'(size_h);
    words      = PIX_W'((area + 1'b1) >> 1);
    xs_load    = done && is_xfer;
    pix_load   = accept && (st_q == ST_PIXEL);
  end

  always_comb begin
    env_we    = gather_acc && first && (cmd_data[DATA_W-1 -: 5] == OP_ENV_TOP);
    env_sel   = cmd_data[DATA_W-6 -: SEL_W];
    env_wdata = cmd_data;
  end

  // next state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    need_d = need_q;
    op_d   = op_q;
    idx_d  = idx_q;
    left_d = left_q;
    case (st_q)
      ST_GATHER: begin
        if (gather_acc) begin
          op_d   = cur_op;
          need_d = cur_need;
          if (done) begin
            cnt_d = '0;
            idx_d = '0;
            if (is_xfer) begin
              left_d = words;
              st_d   = (cur_op == OP_MEM_WRITE) ? ST_PIXEL : ST_GATHER;
            end else begin
              st_d = ST_EMIT;
            end
          end else begin
            cnt_d = LEN_W'(cnt_q + 1'b1);
          end
        end
      end
      ST_EMIT: begin
        if (idx_q == LEN_W'(need_q - 1'b1)) begin
          idx_d = '0;
          st_d  = ST_GATHER;
        end else begin
          idx_d = LEN_W'(idx_q + 1'b1);
        end
      end
      ST_PIXEL: begin
        if (accept) begin
          left_d = left_q - 1'b1;
          if (left_q == PIX_W'(1)) begin
            st_d = ST_GATHER;
          end
        end
      end
      default: st_d = ST_GATHER;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_GATHER;
      cnt_q     <= '0;
      need_q    <= LEN_W'(1);
      op_q      <= '0;
      idx_q     <= '0;
      left_q    <= '0;
      xs_vld_q  <= 1'b0;
      pix_vld_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      need_q    <= need_d;
      op_q      <= op_d;
      idx_q     <= idx_d;
      left_q    <= left_d;
      xs_vld_q  <= xs_load;
      pix_vld_q <= pix_load;
    end
  end

  // transfer datapath registers, loaded with enables
  always_ff @(posedge clk) begin
    if (xs_load) begin
      xfer_is_read <= (cur_op == OP_MEM_READ);
      xfer_x       <= slot_rd[1][XW-1:0];
      xfer_y       <= slot_rd[1][16 +: YW];
      xfer_w       <= size_w;
      xfer_h       <= size_h;
    end
    if (pix_load) begin
      pix_data <= cmd_data;
    end
  end

  assign cmd_ready  = (st_q != ST_EMIT);
  assign pkt_valid  = (st_q == ST_EMIT);
  assign pkt_op     = op_q;
  assign pkt_len    = need_q;
  assign pkt_idx    = idx_q;
  assign pkt_last   = pkt_valid && (idx_q == LEN_W'(need_q - 1'b1));
  assign pkt_word   = slot_rd[idx_q];
  assign xfer_start = xs_vld_q;
  assign pix_valid  = pix_vld_q;

endmodule

// File: rtl/gpf_cmd_framer.sv
module gpf_cmd_framer #(
  parameter int DATA_W  = 32,
  parameter int MAX_LEN = 12,
  parameter int XW      = 10,
  parameter int YW      = 9,
  parameter int N_ENV   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [DATA_W-1:0]        cmd_data,
  output logic                     cmd_ready,
  output logic                     pkt_valid,
  output logic [7:0]               pkt_op,
  output logic [$clog2(MAX_LEN+1)-1:0] pkt_len,
  output logic [$clog2(MAX_LEN+1)-1:0] pkt_idx,
  output logic                     pkt_last,
  output logic [DATA_W-1:0]        pkt_word,
  output logic                     xfer_start,
  output logic                     xfer_is_read,
  output logic [XW-1:0]            xfer_x,
  output logic [YW-1:0]            xfer_y,
  output logic [XW:0]              xfer_w,
  output logic [YW:0]              xfer_h,
  output logic                     pix_valid,
  output logic [DATA_W-1:0]        pix_data,
  output logic [N_ENV*DATA_W-1:0]  env_regs,
  output logic [31:0]              status_word
);

  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int SEL_W = $clog2(N_ENV);

  logic [LEN_W-1:0]  dec_len;
  logic              env_we;
  logic [SEL_W-1:0]  env_sel;
  logic [DATA_W-1:0] env_wdata;

  gpf_len_decode #(.LEN_W(LEN_W)) u_dec (
    .op  (cmd_data[DATA_W-1 -: 8]),
    .len (dec_len)
  );

  gpf_framer_core #(
    .DATA_W(DATA_W), .MAX_LEN(MAX_LEN), .XW(XW), .YW(YW), .N_ENV(N_ENV)
  ) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_data     (cmd_data),
    .cmd_ready    (cmd_ready),
    .dec_len      (dec_len),
    .env_we       (env_we),
    .env_sel      (env_sel),
    .env_wdata    (env_wdata),
    .pkt_valid    (pkt_valid),
    .pkt_op       (pkt_op),
    .pkt_len      (pkt_len),
    .pkt_idx      (pkt_idx),
    .pkt_last     (pkt_last),
    .pkt_word     (pkt_word),
    .xfer_start   (xfer_start),
    .xfer_is_read (xfer_is_read),
    .xfer_x       (xfer_x),
    .xfer_y       (xfer_y),
    .xfer_w       (xfer_w),
    .xfer_h       (xfer_h),
    .pix_valid    (pix_valid),
    .pix_data     (pix_data)
  );

  gpf_env_file #(.DATA_W(DATA_W), .N_ENV(N_ENV)) u_env (
    .clk         (clk),
    .rst_n       (rst_n),
    .env_we      (env_we),
    .env_sel     (env_sel),
    .env_wdata   (env_wdata),
    .env_flat    (env_regs),
    .status_word (status_word)
  );

endmodule

// File: rtl/gpf_cmd_framer_chk.sv
module gpf_cmd_framer_chk #(
  parameter int MAX_LEN = 12,
  parameter int XW      = 10,
  parameter int YW      = 9
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cmd_ready,
  input logic                         pkt_valid,
  input logic [7:0]                   pkt_op,
  input logic [$clog2(MAX_LEN+1)-1:0] pkt_len,
  input logic [$clog2(MAX_LEN+1)-1:0] pkt_idx,
  input logic                         pkt_last,
  input logic                         xfer_start,
  input logic [XW:0]                  xfer_w,
  input logic [YW:0]                  xfer_h,
  input logic                         pix_valid,
  input logic [10:0]                  env1_lo,
  input logic [1:0]                   env6_lo,
  input logic [31:0]                  status_word
);

  // R1: a packet length is always within the table's range
  a_r1_len_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_len >= 1) && (pkt_len <= MAX_LEN));

  // R4: index stays below the length
  a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> pkt_idx < pkt_len);

  // R4: a packet starts at index 0
  a_r4_first_idx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid) |-> pkt_idx == 0);

  // R4: play-out is gapless and steady until the last word
  a_r4_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_last |=> pkt_valid && (pkt_idx == $past(pkt_idx) + 1'b1)
                               && $stable(pkt_op) && $stable(pkt_len));

  // R5: no word is taken while a packet is played out
  a_r5_stall_emit: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !cmd_ready);

  // R7: status low bits follow the two shadow registers one cycle later
  a_r7_status_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> status_word[12:0] == {$past(env6_lo), $past(env1_lo)});

  // R7: upper status bits are fixed
  a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[31:13] == 19'h0A401);

  // R9: a decoded transfer has a non-empty rectangle and is not a packet
  a_r9_xfer_dims: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (xfer_w != 0) && (xfer_h != 0) && !pkt_valid);

  // R10: diverted pixel words never coincide with packets or a new transfer
  a_r10_pix_excl: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> !pkt_valid && !xfer_start);

endmodule

bind gpf_cmd_framer gpf_cmd_framer_chk #(.MAX_LEN(MAX_LEN), .XW(XW), .YW(YW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_ready   (cmd_ready),
  .pkt_valid   (pkt_valid),
  .pkt_op      (pkt_op),
  .pkt_len     (pkt_len),
  .pkt_idx     (pkt_idx),
  .pkt_last    (pkt_last),
  .xfer_start  (xfer_start),
  .xfer_w      (xfer_w),
  .xfer_h      (xfer_h),
  .pix_valid   (pix_valid),
  .env1_lo     (env_regs[DATA_W +: 11]),
  .env6_lo     (env_regs[6*DATA_W +: 2]),
  .status_word (status_word)
);

// File: tb/test_gpf_cmd_framer.sv
`timescale 1ns/1ps
module test_gpf_cmd_framer;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [31:0] cmd_data;
  logic cmd_ready, pkt_valid, pkt_last, xfer_start, xfer_is_read, pix_valid;
  logic [7:0] pkt_op;
  logic [3:0] pkt_len, pkt_idx;
  logic [31:0] pkt_word, pix_data, status_word;
  logic [9:0] xfer_x;
  logic [8:0] xfer_y;
  logic [10:0] xfer_w;
  logic [9:0] xfer_h;
  logic [255:0] env_regs;

  always #10 clk = ~clk;

  gpf_cmd_framer i_gpf_cmd_framer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .pkt_valid(pkt_valid), .pkt_op(pkt_op),
    .pkt_len(pkt_len), .pkt_idx(pkt_idx), .pkt_last(pkt_last),
    .pkt_word(pkt_word), .xfer_start(xfer_start), .xfer_is_read(xfer_is_read),
    .xfer_x(xfer_x), .xfer_y(xfer_y), .xfer_w(xfer_w), .xfer_h(xfer_h),
    .pix_valid(pix_valid), .pix_data(pix_data), .env_regs(env_regs),
    .status_word(status_word)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // parameter-word counts, from the requirements (R2, R3, R9)
  function automatic int ref_extra(input int op);
    int poly[8];
    poly = '{3, 6, 4, 8, 5, 8, 7, 11};
    if (op == 'h02) return 2;
    if (op >= 'h20 && op <= 'h3F) return poly[(op - 'h20) / 4];
    if (op >= 'h40 && op <= 'h47) return 2;
    if (op >= 'h48 && op <= 'h57) return 3;
    if (op >= 'h58 && op <= 'h5F) return 4;
    if (op >= 'h60 && op <= 'h63) return 2;
    if (op >= 'h64 && op <= 'h67) return 3;
    if (op >= 'h68 && op <= 'h6B) return 1;
    if (op >= 'h6C && op <= 'h6F) return 0;
    if (op >= 'h70 && op <= 'h73) return 1;
    if (op >= 'h74 && op <= 'h77) return 2;
    if (op >= 'h78 && op <= 'h7B) return 1;
    if (op >= 'h7C && op <= 'h7F) return 2;
    if (op == 'h80) return 3;
    if (op == 'hA0 || op == 'hC0) return 2;
    return 0;
  endfunction

  // reference model state
  logic [31:0] m_emit[$];
  logic [31:0] m_col[$];
  int          m_em_idx, m_em_len, m_need, m_pix_left;
  logic [7:0]  m_em_op, m_op;
  logic [31:0] m_env[8];
  logic [12:0] m_stlo;
  bit          e_xs, e_xs_rd, e_pv;
  int          e_x, e_y, e_w, e_h;
  logic [31:0] e_pd;

  always @(posedge clk) begin
    bit acc;
    if (!rst_n) begin
      m_emit.delete();
      m_col.delete();
      m_em_idx = 0; m_em_len = 0; m_need = 0; m_pix_left = 0;
      m_em_op = 0; m_op = 0; m_stlo = 0;
      e_xs = 0; e_pv = 0;
      for (int i = 0; i < 8; i++) m_env[i] = {8'(8'hE0 + i), 24'h0};
    end else begin
      acc = cmd_valid && (m_emit.size() == 0);
      m_stlo = {m_env[6][1:0], m_env[1][10:0]};
      e_xs = 0;
      e_pv = 0;
      if (m_emit.size() > 0) begin
        void'(m_emit.pop_front());
        m_em_idx++;
      end
      if (acc) begin
        if (m_pix_left > 0) begin
          e_pv = 1; e_pd = cmd_data; m_pix_left--;
        end else begin
          m_col.push_back(cmd_data);
          if (m_col.size() == 1) begin
            m_op = cmd_data[31:24];
            m_need = 1 + ref_extra(int'(m_op));
            if (m_op[7:3] == 5'b11100) m_env[m_op[2:0]] = cmd_data;
          end
          if (m_col.size() == m_need) begin
            if (m_op == 8'hA0 || m_op == 8'hC0) begin
              e_xs = 1;
              e_xs_rd = (m_op == 8'hC0);
              e_x = int'(m_col[1][9:0]);
              e_y = int'(m_col[1][24:16]);
              e_w = (m_col[2][9:0] == 0) ? 1024 : int'(m_col[2][9:0]);
              e_h = (m_col[2][24:16] == 0) ? 512 : int'(m_col[2][24:16]);
              if (m_op == 8'hA0) m_pix_left = (e_w * e_h + 1) / 2;
            end else begin
              m_emit = m_col;
              m_em_op = m_op;
              m_em_len = m_need;
              m_em_idx = 0;
            end
            m_col.delete();
          end
        end
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(cmd_ready == (m_emit.size() == 0), "R5 cmd_ready", 64'(cmd_ready),
            64'(m_emit.size() == 0));
      check(pkt_valid == (m_emit.size() > 0), "R4 pkt_valid", 64'(pkt_valid),
            64'(m_emit.size() > 0));
      if (m_emit.size() > 0 && pkt_valid) begin
        check(pkt_word == m_emit[0], "R4 pkt_word", 64'(pkt_word), 64'(m_emit[0]));
        check(int'(pkt_idx) == m_em_idx, "R4 pkt_idx", 64'(pkt_idx), 64'(m_em_idx));
        check(pkt_last == (m_emit.size() == 1), "R4 pkt_last", 64'(pkt_last),
              64'(m_emit.size() == 1));
        check(pkt_op == m_em_op, "R1 pkt_op", 64'(pkt_op), 64'(m_em_op));
        if (m_em_op >= 8'h20 && m_em_op <= 8'h3F)
          check(int'(pkt_len) == m_em_len, "R2 pkt_len", 64'(pkt_len), 64'(m_em_len));
        else
          check(int'(pkt_len) == m_em_len, "R1 R3 pkt_len", 64'(pkt_len), 64'(m_em_len));
      end
      check(xfer_start == e_xs, "R9 xfer_start", 64'(xfer_start), 64'(e_xs));
      if (e_xs && xfer_start) begin
        check(xfer_is_read == e_xs_rd, "R9 xfer_is_read", 64'(xfer_is_read), 64'(e_xs_rd));
        check(int'(xfer_x) == e_x, "R9 xfer_x", 64'(xfer_x), 64'(e_x));
        check(int'(xfer_y) == e_y, "R9 xfer_y", 64'(xfer_y), 64'(e_y));
        check(int'(xfer_w) == e_w, "R9 xfer_w", 64'(xfer_w), 64'(e_w));
        check(int'(xfer_h) == e_h, "R9 xfer_h", 64'(xfer_h), 64'(e_h));
      end
      check(pix_valid == e_pv, "R10 pix_valid", 64'(pix_valid), 64'(e_pv));
      if (e_pv && pix_valid)
        check(pix_data == e_pd, "R10 pix_data", 64'(pix_data), 64'(e_pd));
      for (int i = 0; i < 8; i++)
        check(env_regs[i*32 +: 32] == m_env[i], "R6 env_regs",
              64'(env_regs[i*32 +: 32]), 64'(m_env[i]));
      check(status_word == (32'h1480_2000 | 32'(m_stlo)), "R7 status_word",
            64'(status_word), 64'(32'h1480_2000 | 32'(m_stlo)));
    end
  end

  // stimulus helpers; all called at a falling edge
  task automatic put(input logic [31:0] w);
    bit r;
    cmd_valid = 1'b1;
    cmd_data  = w;
    do begin
      r = cmd_ready;
      @(negedge clk);
    end while (!r);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    cmd_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pkt(input logic [7:0] op, input int seed, input int gap);
    put({op, 24'(seed)});
    for (int k = 1; k <= ref_extra(int'(op)); k++) begin
      if (gap > 0) idle(gap);
      put(32'(seed * 7) + 32'(k) * 32'h0101_0101);
    end
  endtask

  task automatic send_xfer(input logic [7:0] op, input logic [31:0] pos,
                           input logic [31:0] size, input int n_pix);
    put({op, 24'h0});
    put(pos);
    put(size);
    for (int k = 0; k < n_pix; k++) put(32'hC0DE_0000 + 32'(k));
  endtask

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_data = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    for (int i = 0; i < 8; i++)
      check(env_regs[i*32 +: 32] == {8'(8'hE0 + i), 24'h0}, "R8 env reset",
            64'(env_regs[i*32 +: 32]), 64'({8'(8'hE0 + i), 24'h0}));
    check(status_word == 32'h1480_2000, "R8 status reset", 64'(status_word),
          64'h1480_2000);
    check(cmd_ready == 1'b1, "R8 ready reset", 64'(cmd_ready), 64'd1);
    check(!pkt_valid && !xfer_start && !pix_valid, "R8 strobes reset",
          64'({pkt_valid, xfer_start, pix_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: one-word packets for zero-entry opcodes
    send_pkt(8'h00, 'h123456, 0);
    send_pkt(8'hFF, 'h000001, 0);
    send_pkt(8'h6D, 'h000002, 0);
    // R2: every polygon group, one with idle gaps inside (R5 buffering)
    send_pkt(8'h20, 'h11, 0);
    send_pkt(8'h24, 'h12, 0);
    send_pkt(8'h28, 'h13, 0);
    send_pkt(8'h2C, 'h14, 1);
    send_pkt(8'h30, 'h15, 0);
    send_pkt(8'h34, 'h16, 0);
    send_pkt(8'h38, 'h17, 0);
    send_pkt(8'h3F, 'h18, 3);
    // R3: remaining table groups
    send_pkt(8'h02, 'h21, 0);
    send_pkt(8'h40, 'h22, 0);
    send_pkt(8'h48, 'h23, 0);
    send_pkt(8'h55, 'h24, 2);
    send_pkt(8'h5C, 'h25, 0);
    send_pkt(8'h60, 'h26, 0);
    send_pkt(8'h64, 'h27, 0);
    send_pkt(8'h68, 'h28, 0);
    send_pkt(8'h70, 'h29, 0);
    send_pkt(8'h74, 'h2A, 0);
    send_pkt(8'h78, 'h2B, 0);
    send_pkt(8'h7C, 'h2C, 0);
    send_pkt(8'h80, 'h2D, 1);
    idle(4);
    // R6, R7: environment words
    put(32'hE100_05A5);
    put(32'hE600_0003);
    put(32'hE3AB_CDEF);
    put(32'hE712_3456);
    idle(3);
    put(32'hE100_0123);
    idle(3);
    // R9, R10: write transfer 3x2 -> 3 pixel words, then framing resumes
    send_xfer(8'hA0, 32'h0005_0003, 32'h0002_0003, 3);
    send_pkt(8'h28, 'h31, 0);
    // R10: 1x1 write -> 1 pixel word
    send_xfer(8'hA0, 32'h01FF_03FF, 32'h0001_0001, 1);
    // R9: read with both size fields zero -> 1024x512, no diversion
    send_xfer(8'hC0, 32'h0123_0045, 32'h0000_0000, 0);
    send_pkt(8'h40, 'h32, 0);
    // R10: width field zero -> 1024 wide, 3 high -> 1536 pixel words
    send_xfer(8'hA0, 32'h0000_0000, 32'h0003_0000, 1536);
    send_pkt(8'h00, 'h33, 0);
    send_pkt(8'h3C, 'h34, 0);
    idle(20);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule